// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Frame Encoder

This block turns pairs of 24-bit audio samples into a self-clocking serial line signal. Every frame carries one left and one right subframe. Each subframe holds a synchronising preamble, the audio word, a validity bit, a user bit, a channel-status bit and a parity bit. The whole frame is then biphase-mark coded. The only timing reference is a master clock at 128 times the sample rate. One clock period is one half-cell on the line, so a frame spans exactly 128 clocks. Frames are grouped into blocks of 192, and the first frame of each block is marked with its own preamble.

The surrounding logic presents a new sample pair and the per-channel side bits on the cycle where `frame_start` is high. Samples narrower than 24 bits are supplied aligned to the top of the word, with zeros filling the low bits. The side bits arrive one per frame per channel, so the channel-status word is built up serially across the block.

When `pro_mode` is set, the block computes an 8-bit checksum of each channel's status bits over the first 184 frames. It then sends that checksum in place of the supplied status bits during the last eight frames of the block.

Top module: `dai_tx_encoder`

## Requirements
- R1: While `rst_n` is low, `tx_out` is 0 and both `frame_start` and `block_start` are 1, because the block sits at half-cell 0 of frame 0. After release, the first frame sent is frame 0 of a block.
- R2: `frame_start` is high for exactly one clock in every 128. `block_start` is high on that clock only when the frame about to be sent has index 0 of the 192-frame block.
- R3: Each subframe opens with an 8-half-cell preamble. Frame 0's left subframe uses pattern 11101000. Other left subframes use 11100010. Right subframes use 11100100. The patterns are listed in time order. They are sent as written when the line was low just before the preamble, and inverted when it was high.
- R4: After the preamble, each of the 28 bit cells starts with a line transition. A cell carrying 1 has a second transition mid-cell, and a cell carrying 0 has none.
- R5: The left subframe occupies half-cells 0 to 63 of a frame and the right subframe half-cells 64 to 127. Within a subframe, cells 4 to 27 carry audio bits 0 to 23, least significant bit first. Cell 28 carries validity, cell 29 user, cell 30 channel status and cell 31 parity. Bit 0 of `vld_in`, `usr_in` and `cs_in` belongs to the left channel and bit 1 to the right channel.
- R6: The parity cell is set so that cells 4 to 31 of every subframe hold an even number of ones. As a result, the line level just before every preamble is the same.
- R7: The samples and side bits present on the clock edge where `frame_start` is high are the ones sent in the frame that starts at that edge. Later changes to the inputs have no effect on that frame.
- R8: With `pro_mode` low at the frame's capture edge, the channel-status cell carries the supplied `cs_in` bit for every frame.
- R9: With `pro_mode` high, frames 184+k (k = 0 to 7) carry bit k of a per-channel CRC in the channel-status cell. The CRC register starts at all ones at frame 0 and is stepped once per frame over that channel's `cs_in` bits for frames 0 to 183. Each step takes the feedback as register bit 7 XOR the input bit, shifts the register left, and XORs in 0x1D when the feedback is 1. This is the polynomial x^8+x^4+x^3+x^2+1.
- R10: With `pro_mode` high, frames 0 to 183 carry the supplied `cs_in` bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 128 times the sample rate; one period per half-cell |
| rst_n | input | 1 | Active-low synchronous reset |
| pro_mode | input | 1 | Selects automatic channel-status CRC insertion, captured per frame |
| left_smp | input | 24 | Left audio sample, top-aligned |
| right_smp | input | 24 | Right audio sample, top-aligned |
| vld_in | input | 2 | Validity bit per channel (bit 0 left) |
| usr_in | input | 2 | User bit per channel (bit 0 left) |
| cs_in | input | 2 | Channel-status bit per channel (bit 0 left) |
| frame_start | output | 1 | High on the clock whose edge captures the next frame's inputs |
| block_start | output | 1 | `frame_start` qualified with frame index 0 of the block |
| tx_out | output | 1 | Biphase-mark coded line signal |

## Verification
Some properties are checked on every clock by the assertions. These are the frame counter staying inside the block, the single-clock width of `frame_start`, and the transition at the start of every data cell and preamble. They also check that the line level is the same just before every preamble, which is how the parity rule shows up on the line, and that the CRC register stays constant while the checksum is being sent. Other behaviours can only be shown by the bench, which decodes the captured half-cells against its own model. These are the correct preamble choice at block boundaries, the bit order of the audio and side bits, the values the parity bits take, the CRC values and their bit order in the last eight frames, and the difference between professional and consumer handling.

// File: rtl/dai_pkg.sv
package dai_pkg;
  localparam int AUD_W = 24;
  localparam int HC_W  = 7;
  localparam int CH_N  = 2;
  localparam int PRE_W = 8;
  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_INIT = 8'hFF;

  typedef enum logic [1:0] {
    PK_BLOCK = 2'd0,
    PK_LEFT  = 2'd1,
    PK_RIGHT = 2'd2
  } pre_kind_e;

  typedef struct packed {
    logic             par;
    logic             cs;
    logic             usr;
    logic             vld;
    logic [AUD_W-1:0] aud;
  } sub_word_t;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic d);
    logic fb;
    fb = c[7] ^ d;
    return {c[6:0], 1'b0} ^ ({8{fb}} & CRC_POLY);
  endfunction

  function automatic logic [PRE_W-1:0] pre_pattern(input pre_kind_e k);
    case (k)
      PK_BLOCK: return 8'b1110_1000;
      PK_LEFT:  return 8'b1110_0010;
      default:  return 8'b1110_0100;
    endcase
  endfunction

  function automatic logic even_fill(input logic [AUD_W+2:0] x);
    return ^x;
  endfunction
endpackage

// File: rtl/dai_timebase.sv
module dai_timebase #(
  parameter int FRAMES = 192,
  parameter int FRM_W  = $clog2(FRAMES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [dai_pkg::HC_W-1:0]  hc_idx,
  output logic [FRM_W-1:0]          frm_idx,
  output logic                      frame_start,
  output logic                      block_start
);
  import dai_pkg::*;
  localparam logic [HC_W-1:0]  HC_LAST  = '1;
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(FRAMES - 1);

  logic frame_end;
  assign frame_end   = (hc_idx == HC_LAST);
  assign frame_start = (hc_idx == '0);
  assign block_start = frame_start && (frm_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc_idx  <= '0;
      frm_idx <= '0;
    end else begin
      hc_idx <= hc_idx + 1'b1;
      if (frame_end)
        frm_idx <= (frm_idx == FRM_LAST) ? '0 : frm_idx + 1'b1;
    end
  end

  p_frame_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_idx <= FRM_LAST);
  p_frame_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

// File: rtl/dai_cs_crc.sv
module dai_cs_crc #(
  parameter int FRAMES = 192,
  parameter int FRM_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [FRM_W-1:0] frm_idx,
  input  logic             pro_mode,
  input  logic             cs_in,
  output logic             cs_out
);
  import dai_pkg::*;
  localparam int CRC_FIRST = FRAMES - 8;
  localparam logic [FRM_W-1:0] CRC_FIRST_V = FRM_W'(CRC_FIRST);

  logic [7:0]       crc_q;
  logic             in_window;
  logic [FRM_W-1:0] off;
  logic [2:0]       sel;

  assign in_window = (frm_idx >= CRC_FIRST_V);
  assign off       = frm_idx - CRC_FIRST_V;
  assign sel       = off[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= CRC_INIT;
      cs_out <= 1'b0;
    end else if (capture) begin
      if (!in_window)
        crc_q <= crc8_step((frm_idx == '0) ? CRC_INIT : crc_q, cs_in);
      cs_out <= (pro_mode && in_window) ? crc_q[sel] : cs_in;
    end
  end

  p_crc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |=> $stable(crc_q));
endmodule

// File: rtl/dai_bmc_enc.sv
module dai_bmc_enc (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [dai_pkg::HC_W-1:0]   hc_idx,
  input  logic                       capture,
  input  logic                       frm_zero,
  input  logic [dai_pkg::AUD_W-1:0]  left_smp,
  input  logic [dai_pkg::AUD_W-1:0]  right_smp,
  input  logic [dai_pkg::CH_N-1:0]   vld_in,
  input  logic [dai_pkg::CH_N-1:0]   usr_in,
  input  logic [dai_pkg::CH_N-1:0]   cs_bits,
  output logic                       tx_out
);
  import dai_pkg::*;
  localparam int WORD_W = $bits(sub_word_t);

  logic [AUD_W-1:0] aud_q [CH_N];
  logic [CH_N-1:0]  vld_q, usr_q;
  logic             pol_q, lvl_q, seen_q;

  logic             sub_sel, half;
  logic [4:0]       slot, bidx;
  logic [2:0]       pk;
  logic             in_pre, pol, data_bit, tx_n;
  sub_word_t        word;
  logic [WORD_W-1:0] word_v;
  pre_kind_e        kind;
  logic [PRE_W-1:0] pat;
  logic             toggle_due, sub_begin;

  assign sub_sel = hc_idx[6];
  assign slot    = hc_idx[5:1];
  assign half    = hc_idx[0];
  assign pk      = hc_idx[2:0];
  assign in_pre  = (slot < 5'd4);
  assign bidx    = slot - 5'd4;

  assign toggle_due = !half && (!in_pre || slot == 5'd0);
  assign sub_begin  = (hc_idx[5:0] == '0);

  always_comb begin
    word.aud = aud_q[sub_sel];
    word.vld = vld_q[sub_sel];
    word.usr = usr_q[sub_sel];
    word.cs  = cs_bits[sub_sel];
    word.par = even_fill({word.cs, word.usr, word.vld, word.aud});
    word_v   = word;
    data_bit = word_v[bidx];
  end

  always_comb begin
    if (sub_sel)       kind = PK_RIGHT;
    else if (frm_zero) kind = PK_BLOCK;
    else               kind = PK_LEFT;
    pat = pre_pattern(kind);
    pol = (pk == 3'd0) ? tx_out : pol_q;
    if (in_pre)    tx_n = pat[3'd7 - pk] ^ pol;
    else if (!half) tx_n = ~tx_out;
    else           tx_n = data_bit ? ~tx_out : tx_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CH_N; i++) aud_q[i] <= '0;
      vld_q  <= '0;
      usr_q  <= '0;
      tx_out <= 1'b0;
      pol_q  <= 1'b0;
      lvl_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (capture) begin
        aud_q[0] <= left_smp;
        aud_q[1] <= right_smp;
        vld_q    <= vld_in;
        usr_q    <= usr_in;
      end
      if (in_pre && pk == 3'd0) pol_q <= tx_out;
      if (sub_begin) begin
        lvl_q  <= tx_out;
        seen_q <= 1'b1;
      end
      tx_out <= tx_n;
    end
  end

  p_cell_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_due |=> (tx_out != $past(tx_out)));
  p_sub_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_begin && seen_q) |-> (tx_out == lvl_q));
endmodule

// File: rtl/dai_tx_encoder.sv
module dai_tx_encoder #(
  parameter int FRAMES = 192,
  parameter int FRM_W  = $clog2(FRAMES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pro_mode,
  input  logic [23:0] left_smp,
  input  logic [23:0] right_smp,
  input  logic [1:0]  vld_in,
  input  logic [1:0]  usr_in,
  input  logic [1:0]  cs_in,
  output logic        frame_start,
  output logic        block_start,
  output logic        tx_out
);
  import dai_pkg::*;

  logic [HC_W-1:0]  hc_idx;
  logic [FRM_W-1:0] frm_idx;
  logic [CH_N-1:0]  cs_bits;

  dai_timebase #(.FRAMES(FRAMES), .FRM_W(FRM_W)) u_time (
    .clk(clk), .rst_n(rst_n), .hc_idx(hc_idx), .frm_idx(frm_idx),
    .frame_start(frame_start), .block_start(block_start)
  );

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_cs
    dai_cs_crc #(.FRAMES(FRAMES), .FRM_W(FRM_W)) u_crc (
      .clk(clk), .rst_n(rst_n), .capture(frame_start), .frm_idx(frm_idx),
      .pro_mode(pro_mode), .cs_in(cs_in[ch]), .cs_out(cs_bits[ch])
    );
  end

  dai_bmc_enc u_enc (
    .clk(clk), .rst_n(rst_n), .hc_idx(hc_idx), .capture(frame_start),
    .frm_zero(frm_idx == '0), .left_smp(left_smp), .right_smp(right_smp),
    .vld_in(vld_in), .usr_in(usr_in), .cs_bits(cs_bits), .tx_out(tx_out)
  );
endmodule

// File: tb/dai_tx_encoder_bench.sv
`timescale 1ns/1ps
module dai_tx_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pro_mode = 1'b0;
  logic [23:0] left_smp = '0, right_smp = '0;
  logic [1:0]  vld_in = '0, usr_in = '0, cs_in = '0;
  logic        frame_start, block_start, tx_out;

  int n_checks = 0;
  int n_fail   = 0;
  int fidx     = 0;
  bit done     = 1'b0;
  bit [7:0] bcrc [2];
  bit hc [128];

  always #2 clk = ~clk;

  dai_tx_encoder u_dai_tx_encoder (
    .clk(clk), .rst_n(rst_n), .pro_mode(pro_mode), .left_smp(left_smp),
    .right_smp(right_smp), .vld_in(vld_in), .usr_in(usr_in), .cs_in(cs_in),
    .frame_start(frame_start), .block_start(block_start), .tx_out(tx_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s frame %0d: actual %0h expected %0h", req, fidx, act, exp);
    end
  endtask

  // explicit tap form of x^8+x^4+x^3+x^2+1
  function automatic bit [7:0] ref_crc(input bit [7:0] c, input bit d);
    bit fb;
    fb = c[7] ^ d;
    return {c[6], c[5], c[4], c[3] ^ fb, c[2] ^ fb, c[1] ^ fb, c[0], fb};
  endfunction

  function automatic bit [7:0] ref_pre(input int sub, input bit first);
    if (sub == 1) return 8'hE4;
    return first ? 8'hE8 : 8'hE2;
  endfunction

  task automatic send_frame(input bit [23:0] l, input bit [23:0] r,
                            input bit [1:0] v, input bit [1:0] u, input bit [1:0] c, input bit pro);
    bit prev, lvl, pulse_ok;
    bit [7:0] got, exp_pre;
    bit [27:0] bits;
    bit [23:0] smp;
    bit exp_c;
    int fpos, togg_bad;
    fpos = fidx % 192;
    check(frame_start === 1'b1, "R2 frame_start", 32'(frame_start), 1);
    check(block_start === (fpos == 0), "R2 block_start", 32'(block_start), 32'(fpos == 0));
    left_smp = l; right_smp = r; vld_in = v; usr_in = u; cs_in = c; pro_mode = pro;
    prev = tx_out;
    pulse_ok = 1'b1;
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      if (k == 0) begin
        // inputs change after capture; frame must be unaffected (R7)
        left_smp = ~l; right_smp = ~r; vld_in = ~v; usr_in = ~u; cs_in = ~c;
      end
      hc[k] = tx_out;
      if (k < 127 && frame_start) pulse_ok = 1'b0;
    end
    check(pulse_ok, "R2 single pulse per 128", 32'(pulse_ok), 1);
    for (int s = 0; s < 2; s++) begin
      int base;
      base = 64 * s;
      lvl = (s == 0) ? prev : hc[63];
      exp_pre = ref_pre(s, fpos == 0) ^ {8{lvl}};
      for (int k = 0; k < 8; k++) got[7-k] = hc[base+k];
      check(got == exp_pre, "R3 preamble", 32'(got), 32'(exp_pre));
      togg_bad = 0;
      for (int j = 4; j < 32; j++) begin
        if (hc[base+2*j] == hc[base+2*j-1]) togg_bad++;
        bits[j-4] = hc[base+2*j] ^ hc[base+2*j+1];
      end
      check(togg_bad == 0, "R4 cell transitions", 32'(togg_bad), 0);
      smp = (s == 0) ? l : r;
      check(bits[23:0] == smp, "R5 R7 audio", 32'(bits[23:0]), 32'(smp));
      check(bits[24] == v[s] && bits[25] == u[s], "R5 validity/user",
            32'(bits[25:24]), 32'({u[s], v[s]}));
      check(^bits == 1'b0, "R6 even parity", 32'(bits[27]), 32'(^bits[26:0]));
      if (pro && fpos >= 184) exp_c = bcrc[s][fpos-184];
      else exp_c = c[s];
      if (!pro)
        check(bits[26] == exp_c, "R8 consumer cs", 32'(bits[26]), 32'(exp_c));
      else if (fpos >= 184)
        check(bits[26] == exp_c, "R9 crc bit", 32'(bits[26]), 32'(exp_c));
      else
        check(bits[26] == exp_c, "R10 pro cs pass", 32'(bits[26]), 32'(exp_c));
      if (fpos < 184) bcrc[s] = ref_crc((fpos == 0) ? 8'hFF : bcrc[s], c[s]);
    end
    fidx++;
  endtask

  task automatic rnd_frame(input bit pro);
    send_frame(24'($urandom), 24'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), pro);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (4) @(negedge clk);
    check(tx_out === 1'b0, "R1 reset line", 32'(tx_out), 0);
    check(frame_start === 1'b1 && block_start === 1'b1, "R1 reset position",
          32'({frame_start, block_start}), 3);
    rst_n = 1'b1;
    // directed corners in consumer mode
    send_frame(24'h000000, 24'h000000, 2'b00, 2'b00, 2'b00, 1'b0);
    send_frame(24'hFFFFFF, 24'hFFFFFF, 2'b11, 2'b11, 2'b11, 1'b0);
    send_frame(24'hABCD00, 24'h123400, 2'b01, 2'b10, 2'b01, 1'b0);
    send_frame(24'h800001, 24'h555555, 2'b10, 2'b01, 2'b10, 1'b0);
    send_frame(24'hAAAAAA, 24'h7FFFFF, 2'b00, 2'b11, 2'b00, 1'b0);
    for (int i = 5; i < 192; i++) rnd_frame(1'b0);
    // professional block with CRC insertion
    for (int i = 0; i < 192; i++) rnd_frame(1'b1);
    // back to consumer: frames 184.. carry raw bits again
    for (int i = 0; i < 192; i++) rnd_frame(1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule